// File: doc/BRIEF.md
# Burst Serial Port with Byte Buffer

This block moves a burst of one to eight bytes over a clock-synchronous three-wire serial link without host help between bytes. The host writes the outgoing bytes into an eight-entry byte store, picks the byte count, and issues a start command. The block then shifts each byte out while it shifts one in. Each received byte replaces the entry it was sent from, so the host reads the replies from the same places once the done flag rises.

The port can act as clock master or as clock slave. As master it makes the serial clock from the system clock. As slave it takes the serial clock from outside through a two-stage synchronizer. An optional select mode gates the whole frame with an active-low select input. While select is high, the clock and data outputs are released and shifting stops.

The control state machine has six states. IDLE goes to WAIT_SEL on an accepted start when select mode is on, and to FETCH otherwise. WAIT_SEL goes to FETCH on a synchronized falling edge of select. FETCH loads the current entry into the transmit shifter and goes to PH_LOW. PH_LOW goes to PH_HIGH on a rising-clock event. For a slave on the final bit of a byte, it goes straight to WRITEBACK instead. PH_HIGH goes to PH_LOW on a falling-clock event, or to WRITEBACK after the final bit. WRITEBACK stores the received byte, then goes back to FETCH for the next entry, or to IDLE after the last entry. In select mode, every state from FETCH onward holds while select is high.

Top module: `fifo_serial_port`

## Requirements
- R1: The byte store has eight entries, numbered 0 to 7. The host writes an entry with `wr_en`/`wr_addr`/`wr_data`, and `rd_data` returns the entry chosen by `rd_addr` in the same cycle. Entries at or above the transfer count keep their host-written value through a transfer.
- R2: A start with `cfg_count` = k (0..7) transfers k+1 bytes, using entries 0 to k in order. Each received byte overwrites the entry it was sent from.
- R3: Bits travel most-significant first. `so` changes only when the serial clock falls. `si` is sampled when the serial clock rises.
- R4: In master mode (`cfg_master` = 1), `sck_out` idles high. Within a byte, every low phase and every high phase lasts exactly HALF = 8 system clocks, giving a 16-clock bit period.
- R5: In slave mode (`cfg_master` = 0), the block drives no clock (`sck_oe` = 0). It shifts on edges of `sck_in` and samples `si`, both taken through two synchronizing flops.
- R6: One cycle after the final bit of the final byte is stored, `done` becomes 1 and `irq` pulses high for exactly one cycle. An accepted start clears `done` on the next cycle.
- R7: `busy` is 1 from the cycle after an accepted start until the cycle `done` rises. A start issued while `busy` is 1 is ignored, and the byte count of the running transfer stays unchanged.
- R8: With `cfg_sel_mode` = 1, an accepted start waits in WAIT_SEL for a falling edge of `sel_n` before any clock edge is produced, so select must be seen high at least one clock first. While `sel_n` is 1, `so_oe` and `sck_oe` are 0 and shifting holds. With `cfg_sel_mode` = 0, `so_oe` is 1 and `sck_oe` equals `cfg_master`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Host write strobe for the byte store |
| wr_addr | input | 3 | Host write entry index |
| wr_data | input | 8 | Host write byte |
| rd_addr | input | 3 | Host read entry index |
| rd_data | output | 8 | Byte at `rd_addr` |
| cfg_count | input | 3 | Number of bytes minus one |
| cfg_master | input | 1 | 1 = clock master, 0 = clock slave |
| cfg_sel_mode | input | 1 | 1 = frame gated by `sel_n` |
| start | input | 1 | Start command, one-cycle pulse |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | Burst complete flag |
| irq | output | 1 | One-cycle completion pulse |
| sck_in | input | 1 | Serial clock from outside (slave) |
| sck_out | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Enable for `sck_out` |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| so_oe | output | 1 | Enable for `so` |
| sel_n | input | 1 | Active-low frame select |

## Verification
A bit counter or entry index that drifts shows first on the wire. The bench sees a burst of the wrong length and a misplaced reply byte in the store within one bit period, which is 16 clocks in master mode. A wrong phase counter shows as a low or high phase that is not 8 clocks long on the first bit. A state machine that leaves WAIT_SEL too early, or fails to hold while select is high, toggles the clock or leaves the enables on within the first dozen cycles. A stuck completion path shows as a missing or doubled `irq` pulse.

// File: rtl/sps_pkg.sv
package sps_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_SEL,
        ST_FETCH,
        ST_PH_LOW,
        ST_PH_HIGH,
        ST_WRITEBACK
    } sps_state_t;
endpackage

// File: rtl/sps_sync.sv
module sps_sync #(
    parameter int          W      = 3,
    parameter logic [W-1:0] INIT  = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] q
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic s1, s2;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s1 <= INIT[g];
                s2 <= INIT[g];
            end else begin
                s1 <= din[g];
                s2 <= s1;
            end
        end
        assign q[g] = s2;
    end
endmodule

// File: rtl/sps_halfgen.sv
module sps_halfgen #(
    parameter int HALF = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt <= '0;
        else if (!run || tick) cnt <= '0;
        else                   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/sps_store.sv
module sps_store #(
    parameter int DEPTH = 8,
    parameter int W     = 8,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_we,
    input  logic [AW-1:0] host_waddr,
    input  logic [W-1:0]  host_wdata,
    input  logic [AW-1:0] host_raddr,
    output logic [W-1:0]  host_rdata,
    input  logic          eng_we,
    input  logic [AW-1:0] eng_addr,
    input  logic [W-1:0]  eng_wdata,
    output logic [W-1:0]  eng_rdata
);
    logic [W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_entry
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (eng_we && eng_addr == AW'(g))
                mem[g] <= eng_wdata;
            else if (host_we && host_waddr == AW'(g))
                mem[g] <= host_wdata;
        end
    end

    assign host_rdata = mem[host_raddr];
    assign eng_rdata  = mem[eng_addr];
endmodule

// File: rtl/fifo_serial_port.sv
module fifo_serial_port
    import sps_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 8,
    parameter int HALF   = 8,
    localparam int AW    = $clog2(DEPTH),
    localparam int BW    = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [AW-1:0]     cfg_count,
    input  logic              cfg_master,
    input  logic              cfg_sel_mode,
    input  logic              start,
    output logic              busy,
    output logic              done,
    output logic              irq,
    input  logic              sck_in,
    output logic              sck_out,
    output logic              sck_oe,
    input  logic              si,
    output logic              so,
    output logic              so_oe,
    input  logic              sel_n
);
    sps_state_t state, nxt;

    logic [DATA_W-1:0] txsh, rxsh, eng_rdata;
    logic [BW-1:0]     bitcnt;
    logic [AW-1:0]     idx, last_idx;
    logic [2:0]        sync_q;
    logic              sel_q, sck_q, si_q, sel_q_d, sck_q_d;
    logic              sck_rise, sck_fall, sel_fall;
    logic              active, tick, rise_ev, fall_ev, si_eff;
    logic              accept, last_bit, eng_we, run;

    // synchronizers for the outside clock, select and data
    sps_sync #(.W(3), .INIT(3'b110)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({sel_n, sck_in, si}),
        .q    (sync_q)
    );
    assign {sel_q, sck_q, si_q} = sync_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q_d <= 1'b1;
            sck_q_d <= 1'b1;
        end else begin
            sel_q_d <= sel_q;
            sck_q_d <= sck_q;
        end
    end
    assign sck_rise = sck_q & ~sck_q_d;
    assign sck_fall = ~sck_q & sck_q_d;
    assign sel_fall = ~sel_q & sel_q_d;

    assign active   = !cfg_sel_mode || !sel_q;
    assign accept   = start && (state == ST_IDLE);
    assign last_bit = (bitcnt == BW'(DATA_W - 1));
    assign run      = cfg_master && active &&
                      (state == ST_PH_LOW || state == ST_PH_HIGH);

    sps_halfgen #(.HALF(HALF)) u_half (
        .clk  (clk),
        .rst_n(rst_n),
        .run  (run),
        .tick (tick)
    );

    assign rise_ev = cfg_master ? (tick && state == ST_PH_LOW)  : sck_rise;
    assign fall_ev = cfg_master ? (tick && state == ST_PH_HIGH) : sck_fall;
    assign si_eff  = cfg_master ? si : si_q;
    assign eng_we  = (state == ST_WRITEBACK) && active;

    sps_store #(.DEPTH(DEPTH), .W(DATA_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_we   (wr_en),
        .host_waddr(wr_addr),
        .host_wdata(wr_data),
        .host_raddr(rd_addr),
        .host_rdata(rd_data),
        .eng_we    (eng_we),
        .eng_addr  (idx),
        .eng_wdata (rxsh),
        .eng_rdata (eng_rdata)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // next state
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:      if (accept) nxt = cfg_sel_mode ? ST_WAIT_SEL : ST_FETCH;
            ST_WAIT_SEL:  if (sel_fall) nxt = ST_FETCH;
            ST_FETCH:     if (active) nxt = ST_PH_LOW;
            ST_PH_LOW:    if (active && rise_ev)
                              nxt = (last_bit && !cfg_master) ? ST_WRITEBACK : ST_PH_HIGH;
            ST_PH_HIGH:   if (active && fall_ev)
                              nxt = last_bit ? ST_WRITEBACK : ST_PH_LOW;
            ST_WRITEBACK: if (active)
                              nxt = (idx == last_idx) ? ST_IDLE : ST_FETCH;
            default:      nxt = ST_IDLE;
        endcase
    end

    // datapath and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txsh     <= '0;
            rxsh     <= '0;
            bitcnt   <= '0;
            idx      <= '0;
            last_idx <= '0;
            done     <= 1'b0;
            irq      <= 1'b0;
        end else begin
            irq <= 1'b0;
            if (accept) begin
                done     <= 1'b0;
                idx      <= '0;
                last_idx <= cfg_count;
            end
            if (active) begin
                unique case (state)
                    ST_FETCH: begin
                        txsh   <= eng_rdata;
                        bitcnt <= '0;
                    end
                    ST_PH_LOW:
                        if (rise_ev) rxsh <= {rxsh[DATA_W-2:0], si_eff};
                    ST_PH_HIGH:
                        if (fall_ev && !last_bit) begin
                            txsh   <= {txsh[DATA_W-2:0], 1'b0};
                            bitcnt <= bitcnt + 1'b1;
                        end
                    ST_WRITEBACK:
                        if (idx == last_idx) begin
                            done <= 1'b1;
                            irq  <= 1'b1;
                        end else begin
                            idx <= idx + 1'b1;
                        end
                    default: ;
                endcase
            end
        end
    end

    // outputs
    always_comb begin
        busy    = (state != ST_IDLE);
        sck_out = !(cfg_master && state == ST_PH_LOW);
        so      = txsh[DATA_W-1];
        so_oe   = !cfg_sel_mode || !sel_n;
        sck_oe  = cfg_master && so_oe;
    end

    // R6: completion pulse is one cycle wide and coincides with the flag
    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    p_irq_with_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> done);
    p_done_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !done);
    // R7: the end of busy is always a completed burst; restart while busy ignored
    p_busy_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);
    p_start_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && busy) |=> $stable(last_idx));
    // R8: while select is high the frame is frozen
    p_sel_freeze_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_sel_mode && sel_q && state != ST_IDLE && state != ST_WAIT_SEL)
        |=> ($stable(txsh) && $stable(bitcnt) && $stable(idx)));
endmodule

// File: tb/sim_fifo_serial_port.sv
module sim_fifo_serial_port;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] wr_addr = '0, rd_addr = '0, cfg_count = '0;
    logic [7:0] wr_data = '0, rd_data;
    logic       cfg_master = 1'b1, cfg_sel_mode = 1'b0, start = 1'b0;
    logic       busy, done, irq;
    logic       sck_in = 1'b1, sck_out, sck_oe, si = 1'b0, so, so_oe, sel_n = 1'b1;

    fifo_serial_port u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cfg_count(cfg_count),
        .cfg_master(cfg_master), .cfg_sel_mode(cfg_sel_mode), .start(start),
        .busy(busy), .done(done), .irq(irq), .sck_in(sck_in), .sck_out(sck_out),
        .sck_oe(sck_oe), .si(si), .so(so), .so_oe(so_oe), .sel_n(sel_n)
    );

    int checks = 0, errors = 0;
    bit finished = 0;
    int irq_cnt = 0, falls = 0, bad_lo = 0, bad_hi = 0;
    logic [7:0] tx_b [8];
    logic [7:0] peer_b [8];
    logic [7:0] seen_b [8];

    // {count-1, seed}
    localparam logic [10:0] VEC [4] = '{
        {3'd0, 8'hA5}, {3'd2, 8'h3C}, {3'd7, 8'h81}, {3'd4, 8'h5E}
    };

    always @(posedge clk) if (irq) irq_cnt <= irq_cnt + 1;
    always @(negedge sck_out) falls <= falls + 1;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int a, input logic [7:0] d);
        @(negedge clk) wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
        @(negedge clk) wr_en = 1'b0;
    endtask

    task automatic host_read(input int a, output logic [7:0] d);
        @(negedge clk) rd_addr = 3'(a);
        #1 d = rd_data;
    endtask

    task automatic pulse_start(input int cnt);
        @(negedge clk) cfg_count = 3'(cnt); start = 1'b1;
        @(negedge clk) start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (!done && n < 20000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic fill(input logic [7:0] seed);
        for (int i = 0; i < 8; i++) begin
            tx_b[i]   = seed + 8'(i * 29);
            peer_b[i] = ~seed ^ 8'(i * 71);
            seen_b[i] = 8'h00;
            host_write(i, tx_b[i]);
        end
    endtask

    // peer device for master mode: presents si after each fall, records so at each rise
    task automatic master_peer(input int nbytes);
        time tf = 0, tr = 0;
        for (int b = 0; b < nbytes * 8; b++) begin
            @(negedge sck_out);
            tf = $time;
            if (b % 8 != 0 && (tf - tr) != 32) bad_hi++;
            si = peer_b[b / 8][7 - (b % 8)];
            @(posedge sck_out);
            tr = $time;
            if ((tr - tf) != 32) bad_lo++;
            seen_b[b / 8][7 - (b % 8)] = so;
        end
    endtask

    task automatic check_result(input int n, input string req);
        logic [7:0] d;
        for (int i = 0; i < 8; i++) begin
            host_read(i, d);
            if (i < n) chk({req, " R2 reply stored in entry"}, d, peer_b[i]);
            else       chk({req, " R1 entry untouched"}, d, tx_b[i]);
        end
        for (int i = 0; i < n; i++)
            chk({req, " R3 MSB-first byte on so"}, seen_b[i], tx_b[i]);
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int i0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state
        chk("R7 busy after reset", busy, 0);
        chk("R6 done after reset", done, 0);
        chk("R6 irq after reset", irq, 0);
        chk("R4 sck idles high", sck_out, 1);
        chk("R8 enables without select mode", {sck_oe, so_oe}, 2'b11);

        // table of master bursts
        for (int v = 0; v < 4; v++) begin
            int n;
            n = int'(VEC[v][10:8]) + 1;
            fill(VEC[v][7:0]);
            i0 = irq_cnt; bad_lo = 0; bad_hi = 0;
            fork
                master_peer(n);
                pulse_start(n - 1);
            join
            wait_done();
            @(negedge clk);
            chk("R6 done after burst", done, 1);
            chk("R6 single irq pulse", irq_cnt - i0, 1);
            chk("R4 low phase 8 clocks", bad_lo, 0);
            chk("R4 high phase 8 clocks", bad_hi, 0);
            chk("R7 busy low after burst", busy, 0);
            check_result(n, "table");
        end

        // start while busy is ignored; start clears done
        fill(8'h17);
        i0 = irq_cnt;
        fork
            master_peer(2);
            begin
                pulse_start(1);
                chk("R6 start clears done", done, 0);
                chk("R7 busy during burst", busy, 1);
                repeat (50) @(negedge clk);
                pulse_start(7);
            end
        join
        wait_done();
        @(negedge clk);
        chk("R7 ignored restart single irq", irq_cnt - i0, 1);
        check_result(2, "R7 restart ignored");

        // select mode, master
        cfg_sel_mode = 1'b1;
        sel_n = 1'b1;
        fill(8'hC3);
        i0 = falls;
        pulse_start(2);
        repeat (40) @(negedge clk);
        chk("R8 waiting for select busy", busy, 1);
        chk("R8 no clock before select", falls - i0, 0);
        chk("R8 released while select high", {sck_oe, so_oe}, 2'b00);
        fork
            master_peer(3);
            begin
                @(negedge clk) sel_n = 1'b0;
                #1 chk("R8 driven while select low", {sck_oe, so_oe}, 2'b11);
            end
        join
        wait_done();
        check_result(3, "R8 select frame");
        @(negedge clk) sel_n = 1'b1;
        cfg_sel_mode = 1'b0;

        // slave mode
        cfg_master = 1'b0;
        fill(8'h69);
        pulse_start(1);
        repeat (4) @(negedge clk);
        chk("R5 slave drives no clock", sck_oe, 0);
        for (int b = 0; b < 16; b++) begin
            @(negedge clk) sck_in = 1'b0;
            repeat (6) @(negedge clk);
            seen_b[b / 8][7 - (b % 8)] = so;
            si = peer_b[b / 8][7 - (b % 8)];
            sck_in = 1'b1;
            repeat (6) @(negedge clk);
        end
        wait_done();
        chk("R5 slave burst done", done, 1);
        check_result(2, "R5 slave");

        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule